// File: doc/BRIEF.md
# Multi-Master SPI Controller

This block is a full-duplex serial peripheral unit that moves one byte at a time between a byte-wide parallel port and a four-pin synchronous serial bus. It works either as the bus master, generating the serial clock from the system clock through an 8-bit divider, or as a slave that follows a clock driven from outside. Any of the four clock polarity and phase combinations can be selected, and data always travels most significant bit first in both directions at once.

The slave-select pin has three roles. In 3-wire operation it is unused. In 4-wire input operation it selects the unit while it is a slave. In master mode it watches for a competing master, and when it is driven active from outside the unit leaves master mode, stops the transfer and raises a mode-fault flag. In 4-wire output operation the pin is a chip select whose level is set by a configuration bit. Each bus pin comes with an output-enable, so an external pad ring can turn off whichever pins the current role does not drive. As a slave, the external clock should run no faster than one tenth of the system clock, because the bus inputs pass through two-stage synchronisers before they are used.

Top module: `spi_mm_ctrl`

## Requirements
- R1: After reset the unit is not master, is not busy, all of done, mode-fault and write-collision read 0, and sck_oe, mosi_oe, miso_oe and ss_n_oe are all 0. The reset configuration is slave, cpol 0, cpha 0, ss mode 2'b01, divider 0.
- R2: In master mode a tx_wr while idle starts a transfer and busy rises on the next clock. The byte leaves on mosi_o most significant bit first while the byte on miso_i is collected. In the clock where the sixteenth clock edge is produced, busy falls, xfer_done is set and rx_data holds the received byte.
- R3: In master mode each half period of sck_o lasts cfg_div+1 system clocks, the first edge included, so the bus clock is the system clock divided by 2*(cfg_div+1). Whenever the master is idle, sck_o rests at cfg_cpol.
- R4: With cfg_cpha=0, data is sampled on the leading (idle-to-active) clock edge and the first bit is already valid before that edge. With cfg_cpha=1, data changes on the leading edge and is sampled on the trailing edge. All four cpol/cpha pairs work, both as master and as slave.
- R5: A tx_wr while busy sets wr_collide on the next clock. The written byte is discarded and the transfer already running finishes with its original data.
- R6: With cfg_ssm=2'b01 in master mode, ss_n_i held low takes the unit out of master mode within 4 clocks. At that point mode_fault=1, busy=0, and sck_oe and mosi_oe are 0.
- R7: With cfg_ssm=2'b10 in master mode, ss_n_oe=1 and ss_n_o equals cfg_cs_lvl. With cfg_ssm=2'b00 or 2'b01, ss_n_oe=0.
- R8: As a slave with cfg_ssm=2'b01, the unit is selected only while ss_n_i is low. While selected it drives miso_oe=1, shifts out the loaded byte on miso_o and collects mosi_i into rx_data after 16 clock edges. While deselected, sck_i edges do nothing and miso_oe=0.
- R9: As a slave with cfg_ssm=2'b00 (3-wire), the unit is always selected and ignores ss_n_i.
- R10: A flag_clr pulse clears xfer_done, mode_fault and wr_collide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load the configuration fields below and abort any transfer |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = sample on the leading edge, 1 = sample on the trailing edge |
| cfg_ssm | input | 2 | Slave-select role: 00 3-wire, 01 4-wire input, 10 4-wire chip-select output |
| cfg_cs_lvl | input | 1 | Level driven on ss_n_o in mode 10 |
| cfg_div | input | 8 | Clock divider; half period is cfg_div+1 clocks |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | 8 | Byte to send |
| flag_clr | input | 1 | Clear the sticky flags |
| rx_data | output | 8 | Last byte received |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Sticky: a byte completed |
| mode_fault | output | 1 | Sticky: master mode was lost to another master |
| wr_collide | output | 1 | Sticky: tx_wr arrived while busy |
| master_active | output | 1 | Current master-enable state |
| sck_i | input | 1 | Serial clock from the bus |
| sck_o | output | 1 | Serial clock to the bus |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data from the bus |
| mosi_o | output | 1 | Master-out data to the bus |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in data from the bus |
| miso_o | output | 1 | Master-in data to the bus |
| miso_oe | output | 1 | Master-in output enable |
| ss_n_i | input | 1 | Slave select from the bus, active low |
| ss_n_o | output | 1 | Chip select to the bus |
| ss_n_oe | output | 1 | Chip select output enable |

## Verification
A wrong edge counter shows up in the first byte. Its edges come at the wrong time, which appears on sck_o within one half period. If xfer_done rises early or late, or rx_data holds a byte shifted by one bit, the mismatch can be seen at the end of that byte. A stuck divider count makes the first half period of sck_o the wrong length, so it is seen within cfg_div+1 clocks of the start. A master-enable bit that fails to clear on a fault leaves sck_oe high four clocks after ss_n_i falls, and the bench checks exactly then. A slave shifter that ignores selection can be seen at miso_oe and xfer_done once a deselected burst of sixteen edges has ended.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

    parameter int DATA_W = 8;
    parameter int DIV_W  = 8;
    localparam int EDGE_W = $clog2(2 * DATA_W);

    // Role of the slave-select pin
    typedef enum logic [1:0] {
        SSM_3WIRE    = 2'b00,
        SSM_4W_IN    = 2'b01,
        SSM_4W_CSOUT = 2'b10,
        SSM_RSVD     = 2'b11
    } ss_mode_e;

    typedef struct packed {
        logic             master;
        logic             cpol;
        logic             cpha;
        ss_mode_e         ssm;
        logic             cs_lvl;
        logic [DIV_W-1:0] div;
    } spi_cfg_t;

    localparam spi_cfg_t CFG_RESET = '{
        master: 1'b0,
        cpol:   1'b0,
        cpha:   1'b0,
        ssm:    SSM_4W_IN,
        cs_lvl: 1'b1,
        div:    '0
    };

    // Sampling happens on the leading edge for phase 0, on the trailing edge for phase 1
    function automatic logic is_sample_edge(input logic leading, input logic cpha);
        return leading ^ cpha;
    endfunction

    function automatic logic slave_selected(input ss_mode_e m, input logic ss_n);
        return (m == SSM_4W_IN) ? ~ss_n : 1'b1;
    endfunction

endpackage

// File: rtl/spi_mm_sync.sv
module spi_mm_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/spi_mm_clkdiv.sv
module spi_mm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
    import spi_mm_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          start,
    input  logic          edge_ev,
    input  logic          leading,
    input  logic          cpha,
    input  logic          sdi,
    output logic          sdo,
    output logic          active,
    output logic          fin,
    output logic [DW-1:0] rx_byte
);
    localparam int EW   = $clog2(2 * DW);
    localparam int LAST = 2 * DW - 1;

    logic [DW-1:0] sh;
    logic [DW-1:0] rxs;
    logic [EW-1:0] edge_idx;
    logic          sample;
    logic          at_last;

    assign sample  = is_sample_edge(leading, cpha);
    assign at_last = (edge_idx == EW'(LAST));
    assign fin     = edge_ev && at_last && !clear;
    assign sdo     = sh[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rxs      <= '0;
            edge_idx <= '0;
            active   <= 1'b0;
            rx_byte  <= '0;
        end else begin
            if (clear) begin
                edge_idx <= '0;
                active   <= 1'b0;
            end else begin
                if (edge_ev) begin
                    if (sample) begin
                        rxs <= {rxs[DW-2:0], sdi};
                    end else if (!(cpha && edge_idx == '0)) begin
                        sh <= {sh[DW-2:0], 1'b0};
                    end
                    if (at_last) begin
                        edge_idx <= '0;
                        active   <= 1'b0;
                        rx_byte  <= sample ? {rxs[DW-2:0], sdi} : rxs;
                    end else begin
                        edge_idx <= edge_idx + 1'b1;
                        active   <= 1'b1;
                    end
                end
                if (start) begin
                    active <= 1'b1;
                end
            end
            if (load) begin
                sh <= load_data;
            end
        end
    end
endmodule

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl
    import spi_mm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic          cfg_master,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic [1:0]    cfg_ssm,
    input  logic          cfg_cs_lvl,
    input  logic [VW-1:0] cfg_div,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_data,
    output logic          busy,
    output logic          xfer_done,
    output logic          mode_fault,
    output logic          wr_collide,
    output logic          master_active,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          mosi_i,
    output logic          mosi_o,
    output logic          mosi_oe,
    input  logic          miso_i,
    output logic          miso_o,
    output logic          miso_oe,
    input  logic          ss_n_i,
    output logic          ss_n_o,
    output logic          ss_n_oe
);
    spi_cfg_t cfg_q;
    spi_cfg_t cfg_in;
    logic     sck_q, sck_d;
    logic     sck_s, mosi_s, ss_s;
    logic     slave_sel, fault_cond;
    logic     m_run, tick, s_edge, edge_ev, leading, sdi;
    logic     eng_clear, m_start, s_load, eng_act, fin, sdo;

    always_comb begin
        cfg_in.master = cfg_master;
        cfg_in.cpol   = cfg_cpol;
        cfg_in.cpha   = cfg_cpha;
        cfg_in.ssm    = ss_mode_e'(cfg_ssm);
        cfg_in.cs_lvl = cfg_cs_lvl;
        cfg_in.div    = cfg_div;
    end

    spi_mm_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_i, mosi_i, ss_n_i}),
        .q   ({sck_s, mosi_s, ss_s})
    );

    assign slave_sel  = slave_selected(cfg_q.ssm, ss_s);
    assign fault_cond = cfg_q.master && (cfg_q.ssm == SSM_4W_IN) && !ss_s;
    assign m_run      = cfg_q.master && eng_act;

    spi_mm_clkdiv #(.DIV_W(VW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (m_run),
        .div  (cfg_q.div),
        .tick (tick)
    );

    assign s_edge    = !cfg_q.master && slave_sel && (sck_s != sck_d);
    assign edge_ev   = cfg_q.master ? tick : s_edge;
    assign leading   = cfg_q.master ? (sck_q == cfg_q.cpol) : (sck_d == cfg_q.cpol);
    assign sdi       = cfg_q.master ? miso_i : mosi_s;
    assign eng_clear = cfg_wr || fault_cond || (!cfg_q.master && !slave_sel);
    assign m_start   = cfg_q.master && tx_wr && !eng_act && !eng_clear;
    assign s_load    = !cfg_q.master && tx_wr && !eng_act;

    spi_mm_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (eng_clear),
        .load      (m_start || s_load),
        .load_data (tx_data),
        .start     (m_start),
        .edge_ev   (edge_ev),
        .leading   (leading),
        .cpha      (cfg_q.cpha),
        .sdi       (sdi),
        .sdo       (sdo),
        .active    (eng_act),
        .fin       (fin),
        .rx_byte   (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= CFG_RESET;
            sck_q      <= 1'b0;
            sck_d      <= 1'b0;
            xfer_done  <= 1'b0;
            mode_fault <= 1'b0;
            wr_collide <= 1'b0;
        end else begin
            sck_d <= sck_s;
            if (flag_clr) begin
                xfer_done  <= 1'b0;
                mode_fault <= 1'b0;
                wr_collide <= 1'b0;
            end
            if (fin) begin
                xfer_done <= 1'b1;
            end
            if (tx_wr && eng_act) begin
                wr_collide <= 1'b1;
            end
            if (cfg_wr) begin
                cfg_q <= cfg_in;
            end
            if (fault_cond) begin
                cfg_q.master <= 1'b0;
                mode_fault   <= 1'b1;
            end
            if (!m_run) begin
                sck_q <= cfg_q.cpol;
            end else if (tick) begin
                sck_q <= ~sck_q;
            end
        end
    end

    assign busy          = eng_act;
    assign master_active = cfg_q.master;
    assign sck_o         = sck_q;
    assign sck_oe        = cfg_q.master;
    assign mosi_o        = sdo;
    assign mosi_oe       = cfg_q.master;
    assign miso_o        = sdo;
    assign miso_oe       = !cfg_q.master && slave_sel;
    assign ss_n_o        = cfg_q.cs_lvl;
    assign ss_n_oe       = cfg_q.master && (cfg_q.ssm == SSM_4W_CSOUT);

endmodule

// File: rtl/spi_mm_ctrl_chk.sv
module spi_mm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_wr,
    input logic       busy,
    input logic       xfer_done,
    input logic       mode_fault,
    input logic       wr_collide,
    input logic       master_active,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic       ss_n_oe,
    input logic       cpol,
    input logic [1:0] ssm
);
    // R3: an idle master holds the clock at its configured rest level
    p_idle_sck_r3: assert property (@(posedge clk) disable iff (rst)
        (master_active && !busy && $past(master_active) && !$past(busy) && $stable(cpol))
            |-> (sck_o == cpol));

    // R2: completion is flagged only as the transfer ends
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_done) |-> !busy);

    // R5: a write during a transfer is reported
    p_collide_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && busy) |=> wr_collide);

    // R6: a mode fault coincides with loss of master mode
    p_fault_drop_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_fault) |-> !master_active);

    // R8: a non-master never drives the clock or master-out pins
    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !master_active |-> (!sck_oe && !mosi_oe));

    // R7: chip select is driven only by a master in output mode
    p_cs_drive_r7: assert property (@(posedge clk) disable iff (rst)
        ss_n_oe |-> (master_active && ssm == 2'b10));
endmodule

bind spi_mm_ctrl spi_mm_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_wr         (tx_wr),
    .busy          (busy),
    .xfer_done     (xfer_done),
    .mode_fault    (mode_fault),
    .wr_collide    (wr_collide),
    .master_active (master_active),
    .sck_o         (sck_o),
    .sck_oe        (sck_oe),
    .mosi_oe       (mosi_oe),
    .ss_n_oe       (ss_n_oe),
    .cpol          (cfg_q.cpol),
    .ssm           (cfg_q.ssm)
);

// File: tb/spi_mm_ctrl_bench.sv
module spi_mm_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr = 0, cfg_master = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_cs_lvl = 1;
    logic [1:0] cfg_ssm = 2'b01;
    logic [7:0] cfg_div = 0;
    logic       tx_wr = 0;
    logic [7:0] tx_data = 0;
    logic       flag_clr = 0;
    logic [7:0] rx_data;
    logic       busy, xfer_done, mode_fault, wr_collide, master_active;
    logic       sck_i = 0, sck_o, sck_oe;
    logic       mosi_i = 0, mosi_o, mosi_oe;
    logic       miso_i = 0, miso_o, miso_oe;
    logic       ss_n_i = 1, ss_n_o, ss_n_oe;

    int   tests = 0;
    int   fails = 0;
    logic mon_en = 0;
    logic exp_cpol = 0;

    always #4 clk = ~clk;

    spi_mm_ctrl u_spi_mm_ctrl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_master(cfg_master),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_ssm(cfg_ssm),
        .cfg_cs_lvl(cfg_cs_lvl), .cfg_div(cfg_div), .tx_wr(tx_wr),
        .tx_data(tx_data), .flag_clr(flag_clr), .rx_data(rx_data),
        .busy(busy), .xfer_done(xfer_done), .mode_fault(mode_fault),
        .wr_collide(wr_collide), .master_active(master_active),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Per-clock model check (R3): an idle master rests at the configured polarity
    always @(negedge clk) begin
        if (mon_en && !rst && master_active && !busy) begin
            tests++;
            if (sck_o !== exp_cpol) begin
                fails++;
                $display("FAIL R3 idle sck: actual %0h expected %0h", sck_o, exp_cpol);
            end
        end
    end

    task automatic cfg_set(input logic m, cp, ph, input logic [1:0] sm,
                           input logic cs, input logic [7:0] dv);
        mon_en = 0;
        @(negedge clk);
        cfg_master = m; cfg_cpol = cp; cfg_cpha = ph; cfg_ssm = sm;
        cfg_cs_lvl = cs; cfg_div = dv; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        repeat (2) @(negedge clk);
        exp_cpol = cp;
        mon_en = 1;
    endtask

    task automatic pulse_clr();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
    endtask

    // Bench acts as an external slave device while the unit is master
    task automatic mxfer(input logic [7:0] tx, input logic [7:0] sb, input logic cp,
                         input logic ph, input logic [7:0] dv, input int coll);
        logic [7:0] got;
        int         i, edges, since, cyc;
        logic       prev, lead, smp;
        bit         hp_ok;
        cfg_set(1, cp, ph, 2'b01, 1, dv);
        miso_i = sb[7];
        got = 0; i = 0; edges = 0; since = 0; cyc = 0; hp_ok = 1;
        @(negedge clk) begin tx_data = tx; tx_wr = 1; end
        @(negedge clk) tx_wr = 0;
        prev = sck_o;
        check("R2 busy after start", busy, 1);
        while (edges < 16 && cyc < 20000) begin
            @(negedge clk);
            cyc++; since++;
            if (tx_wr) begin
                tx_wr = 0;
                check("R5 collision flag", wr_collide, 1);
            end
            if (cyc == coll) begin
                tx_data = 8'h3C; tx_wr = 1;
            end
            if (sck_o !== prev) begin
                if (since != int'(dv) + 1) hp_ok = 0;
                lead = (prev == cp);
                prev = sck_o;
                smp  = lead ^ ph;
                if (smp) begin
                    got = {got[6:0], mosi_o};
                end else if (ph) begin
                    if (i < 8) miso_i = sb[7-i];
                    i++;
                end else begin
                    i++;
                    if (i < 8) miso_i = sb[7-i];
                end
                edges++;
                since = 0;
            end
        end
        check("R2 done flag", xfer_done, 1);
        check("R2 busy cleared", busy, 0);
        check("R2 R4 received byte", rx_data, sb);
        check("R4 transmitted byte MSB first", got, tx);
        check("R3 half period", hp_ok, 1);
        check("R3 sck rests at cpol", sck_o, cp);
        pulse_clr();
        @(negedge clk);
        check("R10 done cleared", xfer_done, 0);
        check("R10 collide cleared", wr_collide, 0);
    endtask

    // Bench acts as the external master while the unit is a slave
    task automatic sxfer(input logic [7:0] tx, input logic [7:0] mb, input logic cp,
                         input logic ph, input bit three);
        logic [7:0] got;
        int         i;
        logic       smp;
        mon_en = 0;
        sck_i = cp;
        repeat (3) @(negedge clk);
        cfg_set(0, cp, ph, three ? 2'b00 : 2'b01, 1, 0);
        @(negedge clk) begin tx_data = tx; tx_wr = 1; end
        @(negedge clk) tx_wr = 0;
        if (!three) ss_n_i = 0;
        mosi_i = mb[7];
        got = 0; i = 0;
        repeat (4) @(negedge clk);
        check(three ? "R9 miso driven" : "R8 miso driven", miso_oe, 1);
        for (int k = 0; k < 16; k++) begin
            repeat (8) @(negedge clk);
            smp = ((k % 2) == 0) ^ ph;
            if (smp) got = {got[6:0], miso_o};
            sck_i = ~sck_i;
            if (!smp) begin
                if (ph) begin
                    if (i < 8) mosi_i = mb[7-i];
                    i++;
                end else begin
                    i++;
                    if (i < 8) mosi_i = mb[7-i];
                end
            end
        end
        repeat (6) @(negedge clk);
        check(three ? "R9 slave done" : "R8 slave done", xfer_done, 1);
        check("R4 slave received", rx_data, mb);
        check("R4 slave sent", got, tx);
        ss_n_i = 1;
        repeat (4) @(negedge clk);
        check(three ? "R9 ss ignored" : "R8 deselect releases miso", miso_oe, three ? 1 : 0);
        pulse_clr();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 master off", master_active, 0);
        check("R1 busy", busy, 0);
        check("R1 flags", {xfer_done, mode_fault, wr_collide}, 0);
        check("R1 enables", {sck_oe, mosi_oe, miso_oe, ss_n_oe}, 0);

        // R2 R3 R4: all four clock modes, several dividers, divider extremes
        mxfer(8'hA5, 8'h3C, 0, 0, 8'd0,   -1);
        mxfer(8'h5A, 8'hC3, 0, 1, 8'd1,   -1);
        mxfer(8'h96, 8'h69, 1, 0, 8'd3,   -1);
        mxfer(8'hF0, 8'h0F, 1, 1, 8'd2,   -1);
        mxfer(8'h81, 8'h7E, 0, 0, 8'd255, -1);

        // R5: collision mid-transfer, original byte still sent
        mxfer(8'hA5, 8'h5A, 0, 0, 8'd3, 10);

        // R7: chip select output and its absence in other roles
        cfg_set(1, 0, 0, 2'b10, 0, 1);
        check("R7 cs enabled", ss_n_oe, 1);
        check("R7 cs low", ss_n_o, 0);
        cfg_set(1, 0, 0, 2'b10, 1, 1);
        check("R7 cs high", ss_n_o, 1);
        cfg_set(1, 0, 0, 2'b00, 0, 1);
        check("R7 3-wire no cs", ss_n_oe, 0);
        cfg_set(1, 0, 0, 2'b01, 0, 1);
        check("R7 fault-input no cs", ss_n_oe, 0);

        // R6: mode fault while transferring
        cfg_set(1, 0, 0, 2'b01, 1, 8'd20);
        @(negedge clk) begin tx_data = 8'hC7; tx_wr = 1; end
        @(negedge clk) tx_wr = 0;
        repeat (10) @(negedge clk);
        mon_en = 0;
        ss_n_i = 0;
        repeat (4) @(negedge clk);
        check("R6 master dropped", master_active, 0);
        check("R6 fault flag", mode_fault, 1);
        check("R6 transfer aborted", busy, 0);
        check("R6 pins released", {sck_oe, mosi_oe}, 0);
        check("R6 no done", xfer_done, 0);
        ss_n_i = 1;
        repeat (3) @(negedge clk);
        pulse_clr();
        @(negedge clk);
        check("R10 fault cleared", mode_fault, 0);

        // R8 R9: slave transfers
        sxfer(8'h3C, 8'hA5, 0, 0, 0);
        sxfer(8'hC3, 8'h5A, 1, 1, 0);
        sxfer(8'h96, 8'h2D, 0, 1, 0);
        sxfer(8'hE7, 8'h18, 1, 0, 1);

        // R8: deselected slave ignores clock
        sck_i = 0;
        repeat (3) @(negedge clk);
        cfg_set(0, 0, 0, 2'b01, 1, 0);
        ss_n_i = 1;
        for (int k = 0; k < 16; k++) begin
            repeat (8) @(negedge clk);
            sck_i = ~sck_i;
        end
        repeat (6) @(negedge clk);
        check("R8 deselected no done", xfer_done, 0);
        check("R8 deselected not busy", busy, 0);
        check("R8 deselected miso off", miso_oe, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule